// File: doc/BRIEF.md
# Receive Line Activity Qualifier

This block decides whether real traffic is present on a twisted-pair receive input. A comparator in front of it produces a one-cycle strobe for each line pulse that crosses the active threshold. The block counts these pulses. When two of them arrive close enough together, it declares the line active. Once the line is active, it lowers the comparator threshold from the squelch level to the unsquelch level. It also releases the adaptive receive circuits from their held state and tells clock recovery to follow the incoming data instead of the local 125 MHz transmit clock.

How the active state ends depends on the speed. At 100 Mb/s the line goes inactive after a fixed window with no pulses (150 cycles of the 125 MHz clock by default). At 10 Mb/s it goes inactive in the first cycle in which the Manchester decoder no longer reports valid data. Isolated noise pulses never build up toward detection, because the pulse count is discarded whenever the idle window passes without a pulse.

Top module: `line_activity_qualifier`

## Requirements
- R1: After reset, signal_detect is 0, threshold_select is 0 (squelch level), adapt_release is 0 (adaptive circuits held) and cdr_ref_select is 0 (local transmit clock).
- R2: A pulse strobe that comes no more than IDLE_CYCLES clock edges after the previous one counts toward detection. signal_detect becomes 1 right after the clock edge that samples the second such pulse.
- R3: A lone pulse never asserts signal_detect. Pulses spaced more than IDLE_CYCLES edges apart never assert it either, because the count is cleared at the end of each idle window.
- R4: threshold_select (1 = unsquelch level), adapt_release (1 = released) and cdr_ref_select (1 = received data) always equal signal_detect in the same cycle, so all three return to 0 whenever detection drops.
- R5: With speed_100 = 1, signal_detect drops at exactly the IDLE_CYCLES-th consecutive pulse-free clock edge after the last pulse. Any pulse restarts that window.
- R6: With speed_100 = 0, signal_detect drops at the first clock edge that samples manchester_valid = 0. While manchester_valid stays 1, no idle window ends detection.
- R7: After signal_detect drops, the pulse count starts from zero, so one further pulse does not re-assert detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_strobe | input | 1 | One-cycle strobe per line pulse above threshold |
| manchester_valid | input | 1 | 10 Mb/s decoder reports valid Manchester data |
| speed_100 | input | 1 | 1 = 100 Mb/s rule, 0 = 10 Mb/s rule |
| signal_detect | output | 1 | Line activity qualified |
| threshold_select | output | 1 | 0 = squelch level, 1 = unsquelch level |
| adapt_release | output | 1 | 1 = adaptive circuits released |
| cdr_ref_select | output | 1 | 0 = transmit clock, 1 = received data |

## Verification
A wrong idle counter shows up at the ports as detection that drops one or more cycles early or late after the last pulse. The same fault shows up as a pulse pair at a gap of exactly IDLE_CYCLES or IDLE_CYCLES+1 being judged the wrong way. Both are visible within one idle window. A stale pulse count shows up as detection on the first pulse after a drop, or on widely spaced noise. A wrong output mapping shows up as a threshold or clock-reference pin that disagrees with signal_detect in the very cycle detection changes.

// File: rtl/laq_pkg.sv
package laq_pkg;
    // Sense of the comparator threshold control
    typedef enum logic {
        THR_SQUELCH   = 1'b0,
        THR_UNSQUELCH = 1'b1
    } thr_level_e;

    // Which clock the recovery loop follows
    typedef enum logic {
        REF_TX_CLOCK = 1'b0,
        REF_RX_DATA  = 1'b1
    } cdr_ref_e;
endpackage

// File: rtl/laq_idle_timer.sv
// Idle timer: counts clock edges since the last pulse strobe, saturating at
// IDLE_CYCLES. Reports whether the last pulse is still inside the window and
// flags the edge at which the window closes. Assumes IDLE_CYCLES >= 2.
module laq_idle_timer #(
    parameter int IDLE_CYCLES = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_strobe,
    output logic recent,
    output logic window_end
);
    localparam int CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

    logic [CW-1:0] idle_cnt;

    // Restart on a pulse, otherwise count up to the saturation limit
    always_ff @(posedge clk) begin
        if (!rst_n)
            idle_cnt <= LIMIT;
        else if (pulse_strobe)
            idle_cnt <= '0;
        else if (idle_cnt != LIMIT)
            idle_cnt <= idle_cnt + 1'b1;
    end

    // Window status decoded from the count
    always_comb begin
        recent     = (idle_cnt != LIMIT);
        window_end = !pulse_strobe && (idle_cnt == LIMIT - 1'b1);
    end

    assert_idle_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= LIMIT);
    assert_pulse_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_strobe |=> (idle_cnt == '0));
endmodule

// File: rtl/laq_detect_fsm.sv
// Detection state: accumulates pulses that fall inside the idle window,
// raises detection on the PULSES_NEEDED-th, and drops it on the
// speed-dependent rule. Assumes PULSES_NEEDED >= 2.
module laq_detect_fsm #(
    parameter int PULSES_NEEDED = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_strobe,
    input  logic recent,
    input  logic window_end,
    input  logic manchester_valid,
    input  logic speed_100,
    output logic detect
);
    localparam int PW = $clog2(PULSES_NEEDED + 1);
    localparam logic [PW-1:0] LAST = PW'(PULSES_NEEDED - 1);

    logic [PW-1:0] pulse_cnt;
    logic          drop;

    // Deassertion rule chosen by speed
    always_comb drop = speed_100 ? window_end : !manchester_valid;

    // Pulse accumulation and detect flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            detect    <= 1'b0;
            pulse_cnt <= '0;
        end else if (detect) begin
            if (drop) begin
                detect    <= 1'b0;
                pulse_cnt <= '0;
            end
        end else if (pulse_strobe) begin
            if (recent && pulse_cnt >= LAST) begin
                detect    <= 1'b1;
                pulse_cnt <= '0;
            end else begin
                pulse_cnt <= recent ? pulse_cnt + 1'b1 : PW'(1);
            end
        end else if (window_end) begin
            pulse_cnt <= '0;
        end
    end

    assert_rise_on_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(detect) |-> $past(pulse_strobe));
    assert_fast_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        detect && speed_100 && window_end |=> !detect);
    assert_manch_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        detect && !speed_100 && !manchester_valid |=> !detect);
    assert_slow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        detect && !speed_100 && manchester_valid |=> detect);
    assert_count_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(detect) |-> (pulse_cnt == '0));
endmodule

// File: rtl/laq_control_map.sv
// Maps the detect flag onto the threshold, adaptation and clock-reference
// controls. Purely combinational, so all controls change together.
module laq_control_map
    import laq_pkg::*;
(
    input  logic       detect,
    output thr_level_e thr_level,
    output logic       adapt_go,
    output cdr_ref_e   cdr_ref
);
    // Select unsquelch level, release adaptation and follow data when active
    always_comb begin
        thr_level = detect ? THR_UNSQUELCH : THR_SQUELCH;
        adapt_go  = detect;
        cdr_ref   = detect ? REF_RX_DATA : REF_TX_CLOCK;
    end
endmodule

// File: rtl/line_activity_qualifier.sv
// Top: qualifies receive line activity from pulse strobes and drives the
// threshold, adaptation release and clock recovery reference controls.
// Assumes pulse_strobe is already synchronous to clk.
module line_activity_qualifier
    import laq_pkg::*;
#(
    parameter int IDLE_CYCLES   = 150,
    parameter int PULSES_NEEDED = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_strobe,
    input  logic manchester_valid,
    input  logic speed_100,
    output logic signal_detect,
    output logic threshold_select,
    output logic adapt_release,
    output logic cdr_ref_select
);
    logic       recent;
    logic       window_end;
    logic       detect;
    thr_level_e thr_level;
    cdr_ref_e   cdr_ref;
    logic       adapt_go;

    laq_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .pulse_strobe(pulse_strobe),
        .recent(recent), .window_end(window_end));

    laq_detect_fsm #(.PULSES_NEEDED(PULSES_NEEDED)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pulse_strobe(pulse_strobe),
        .recent(recent), .window_end(window_end),
        .manchester_valid(manchester_valid), .speed_100(speed_100),
        .detect(detect));

    laq_control_map u_map (
        .detect(detect), .thr_level(thr_level),
        .adapt_go(adapt_go), .cdr_ref(cdr_ref));

    // Drive the output pins
    always_comb begin
        signal_detect    = detect;
        threshold_select = thr_level;
        adapt_release    = adapt_go;
        cdr_ref_select   = cdr_ref;
    end

    assert_controls_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (threshold_select == signal_detect) && (adapt_release == signal_detect)
        && (cdr_ref_select == signal_detect));
endmodule

// File: tb/test_line_activity_qualifier.sv
module test_line_activity_qualifier;
    localparam int IDLE = 150;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pulse_strobe = 1'b0;
    logic manchester_valid = 1'b0;
    logic speed_100 = 1'b1;
    logic signal_detect, threshold_select, adapt_release, cdr_ref_select;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    line_activity_qualifier #(.IDLE_CYCLES(IDLE), .PULSES_NEEDED(2)) i_line_activity_qualifier (
        .clk(clk), .rst_n(rst_n), .pulse_strobe(pulse_strobe),
        .manchester_valid(manchester_valid), .speed_100(speed_100),
        .signal_detect(signal_detect), .threshold_select(threshold_select),
        .adapt_release(adapt_release), .cdr_ref_select(cdr_ref_select));

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // All three controls must mirror the detect state (R4)
    task automatic check_all(input string req, input logic exp);
        check(req, signal_detect, exp);
        check({req, " R4 thr"}, threshold_select, exp);
        check({req, " R4 adapt"}, adapt_release, exp);
        check({req, " R4 cdr"}, cdr_ref_select, exp);
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse();
        pulse_strobe = 1'b1;
        edges(1);
        pulse_strobe = 1'b0;
    endtask

    initial begin
        edges(3);
        check_all("R1 reset", 1'b0);
        rst_n = 1'b1;
        edges(2);
        check_all("R1 after release", 1'b0);

        // R2/R3: sweep pulse-pair gaps at 100 Mb/s across the window edge
        speed_100 = 1'b1;
        for (int g = 1; g <= IDLE + 10; g++) begin
            pulse();
            check("R3 single pulse", signal_detect, 1'b0);
            edges(g - 1);
            pulse();
            check_all((g <= IDLE) ? "R2 pair inside window" : "R3 pair outside window",
                      (g <= IDLE) ? 1'b1 : 1'b0);
            edges(IDLE + 2);
            check("R5 dropped after idle", signal_detect, 1'b0);
        end

        // R5: exact drop cycle, and a pulse restarts the window
        pulse(); pulse();
        check("R2 back-to-back", signal_detect, 1'b1);
        edges(100);
        pulse();
        edges(IDLE - 1);
        check("R5 still high at window-1", signal_detect, 1'b1);
        edges(1);
        check_all("R5 low at window", 1'b0);

        // R7: one pulse after a drop is not enough
        pulse();
        check("R7 no re-detect on one pulse", signal_detect, 1'b0);
        pulse();
        check("R7 second pulse re-detects", signal_detect, 1'b1);
        edges(IDLE + 2);

        // R3: noise pulses every IDLE+1 edges never accumulate
        for (int k = 0; k < 6; k++) begin
            pulse();
            check("R3 sparse noise", signal_detect, 1'b0);
            edges(IDLE);
        end

        // R6: 10 Mb/s rule
        speed_100 = 1'b0;
        manchester_valid = 1'b1;
        pulse(); pulse();
        check_all("R6 detect at 10M", 1'b1);
        edges(3 * IDLE);
        check("R6 no idle drop at 10M", signal_detect, 1'b1);
        manchester_valid = 1'b0;
        edges(1);
        check_all("R6 drop on Manchester loss", 1'b0);
        manchester_valid = 1'b1;
        pulse();
        check("R7 10M one pulse after drop", signal_detect, 1'b0);
        pulse();
        check("R6 redetect at 10M", signal_detect, 1'b1);

        // R1: reset from the active state
        rst_n = 1'b0;
        edges(1);
        check_all("R1 reset while active", 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule